// File: doc/BRIEF.md
# Single-Step Nonrestoring Divide Unit

This block holds the working state of a one-bit-per-step nonrestoring division: a partial remainder/quotient register, a divisor register and three flag bits (the quotient flag Q, the divisor sign flag M and the transfer bit T). Each division step shifts the working register left by one and feeds T in at the bottom. It then adds or subtracts the divisor, depending on the previous Q and on M. It recomputes Q from the bit shifted out, from M and from the carry or borrow, and sets T to show whether Q now equals M. Quotient bits therefore enter the register through T on each following step.

Software-visible use goes through three commands. A setup command loads the register, the divisor and the three flags directly. A single-step command performs one iteration. A run command makes an internal sequencer issue a fixed number of consecutive steps, one per clock, and then pulse done. Sign pre-correction of the operands is not part of this block. The caller prepares the operands and chooses the flag values at setup.

Top module: `ndiv_unit`

## Requirements
- R1: After reset the working register, divisor, Q, M and T are all zero, and busy and done are low.
- R2: While idle, setup_en loads rem_out, the divisor, q_out, m_out and t_out from the setup inputs at the next clock edge.
- R3: A step shifts the working register left by one with the old T in bit 0. It subtracts the divisor when the previous Q equals M and adds it otherwise, on WIDTH-bit unsigned values.
- R4: After a step, q_out equals the old register MSB XOR M XOR c. Here c is the carry of the add (sum smaller than the shifted value) or the borrow of the subtract (difference larger than the shifted value).
- R5: After a step, t_out is 1 exactly when q_out equals m_out. A step never changes m_out or the divisor.
- R6: run_start while idle raises busy at the next edge. Exactly RUN_STEPS steps (default 32) follow on consecutive edges. At the edge of the final step busy falls and done rises for one cycle only.
- R7: setup_en is ignored while busy. Setup values applied mid-run leave the final result equal to an undisturbed run.
- R8: step_en and run_start are ignored while busy. The run is neither lengthened nor given extra steps.
- R9: When commands coincide while idle, setup wins over run_start, and run_start wins over step_en. The edge that accepts run_start performs no step.
- R10: With no command and no run in progress, the register and all flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| setup_en | input | 1 | Load register, divisor and flags |
| setup_rem | input | WIDTH | Value loaded into the working register |
| setup_div | input | WIDTH | Value loaded into the divisor |
| setup_q | input | 1 | Value loaded into Q |
| setup_m | input | 1 | Value loaded into M |
| setup_t | input | 1 | Value loaded into T |
| step_en | input | 1 | Perform one division step |
| run_start | input | 1 | Start a run of RUN_STEPS steps |
| rem_out | output | WIDTH | Working register |
| q_out | output | 1 | Q flag |
| m_out | output | 1 | M flag |
| t_out | output | 1 | T flag |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The checker watches several properties on every cycle. It sees that T tracks Q==M after each step, that M stays constant through steps and whole runs, that setup loads the flags, that an idle unit holds its state, and that done is a single pulse arriving exactly RUN_STEPS busy cycles after the start. The arithmetic itself needs the bench's scenarios. The value of the shifted-and-added register, the carry and borrow into Q, and the way quotient bits chain through T over a full run are compared against an independent model. The vectors cover positive and negative divisors, a zero divisor and extreme dividends. Proving that commands are ignored mid-run, and the priority between coinciding commands, also depends on those scenarios.

// File: rtl/ndiv_pkg.sv
package ndiv_pkg;

   // Command accepted on a given cycle after priority decoding
   typedef enum logic [1:0] {
      CMD_NONE  = 2'd0,
      CMD_SETUP = 2'd1,
      CMD_RUN   = 2'd2,
      CMD_STEP  = 2'd3
   } ndiv_cmd_e;

   // Flag bundle held next to the working register
   typedef struct packed {
      logic q;
      logic m;
      logic t;
   } ndiv_flags_t;

   // Carry/borrow detection variants for the step datapath
   localparam int CB_COMPARE  = 0;
   localparam int CB_EXTENDED = 1;

endpackage

// File: rtl/ndiv_cmd_decode.sv
module ndiv_cmd_decode
   import ndiv_pkg::*;
(
   input  logic      busy_i,
   input  logic      setup_i,
   input  logic      run_i,
   input  logic      step_i,
   output ndiv_cmd_e cmd_o
);

   // Priority: setup > run > single step; nothing is accepted while busy
   always_comb begin
      cmd_o = CMD_NONE;
      if (!busy_i) begin
         if (setup_i)
            cmd_o = CMD_SETUP;
         else if (run_i)
            cmd_o = CMD_RUN;
         else if (step_i)
            cmd_o = CMD_STEP;
      end
   end

endmodule

// File: rtl/ndiv_step.sv
module ndiv_step
   import ndiv_pkg::*;
#(
   parameter int WIDTH    = 32,
   parameter int CB_STYLE = CB_COMPARE
) (
   input  logic [WIDTH-1:0] rem_i,
   input  logic [WIDTH-1:0] div_i,
   input  ndiv_flags_t      flg_i,
   output logic [WIDTH-1:0] rem_o,
   output ndiv_flags_t      flg_o
);

   if (WIDTH < 2) begin : g_bad_width
      $error("ndiv_step: WIDTH must be at least 2");
   end
   if (CB_STYLE != CB_COMPARE && CB_STYLE != CB_EXTENDED) begin : g_bad_style
      $error("ndiv_step: unknown CB_STYLE");
   end

   logic             top_bit;
   logic [WIDTH-1:0] shifted;
   logic             do_sub;
   logic [WIDTH-1:0] result;
   logic             cb;

   assign top_bit = rem_i[WIDTH-1];
   assign shifted = {rem_i[WIDTH-2:0], flg_i.t};
   assign do_sub  = (flg_i.q == flg_i.m);

   if (CB_STYLE == CB_COMPARE) begin : g_cmp
      // Carry/borrow recovered by comparing against the pre-operation value
      always_comb begin
         if (do_sub) begin
            result = shifted - div_i;
            cb     = (result > shifted);
         end else begin
            result = shifted + div_i;
            cb     = (result < shifted);
         end
      end
   end else begin : g_ext
      // Carry/borrow taken from one extra adder bit
      logic [WIDTH:0] wide;
      always_comb begin
         if (do_sub)
            wide = {1'b0, shifted} - {1'b0, div_i};
         else
            wide = {1'b0, shifted} + {1'b0, div_i};
         result = wide[WIDTH-1:0];
         cb     = wide[WIDTH];
      end
   end

   always_comb begin
      rem_o   = result;
      flg_o.m = flg_i.m;
      flg_o.q = top_bit ^ flg_i.m ^ cb;
      flg_o.t = (flg_o.q == flg_i.m);
   end

endmodule

// File: rtl/ndiv_seq.sv
module ndiv_seq #(
   parameter int RUN_STEPS = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);

   if (RUN_STEPS < 1) begin : g_bad_steps
      $error("ndiv_seq: RUN_STEPS must be at least 1");
   end

   localparam int CW = (RUN_STEPS > 1) ? $clog2(RUN_STEPS) : 1;
   localparam logic [CW-1:0] LAST = CW'(RUN_STEPS - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_o <= 1'b0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (busy_o) begin
            if (cnt_q == LAST) begin
               busy_o <= 1'b0;
               done_o <= 1'b1;
               cnt_q  <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else if (start_i) begin
            busy_o <= 1'b1;
            cnt_q  <= '0;
         end
      end
   end

endmodule

// File: rtl/ndiv_unit.sv
module ndiv_unit
   import ndiv_pkg::*;
#(
   parameter int WIDTH     = 32,
   parameter int RUN_STEPS = WIDTH,
   parameter int CB_STYLE  = CB_COMPARE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             setup_en,
   input  logic [WIDTH-1:0] setup_rem,
   input  logic [WIDTH-1:0] setup_div,
   input  logic             setup_q,
   input  logic             setup_m,
   input  logic             setup_t,
   input  logic             step_en,
   input  logic             run_start,
   output logic [WIDTH-1:0] rem_out,
   output logic             q_out,
   output logic             m_out,
   output logic             t_out,
   output logic             busy,
   output logic             done
);

   if (WIDTH < 2) begin : g_bad_width
      $error("ndiv_unit: WIDTH must be at least 2");
   end
   if (RUN_STEPS < 1) begin : g_bad_steps
      $error("ndiv_unit: RUN_STEPS must be at least 1");
   end

   ndiv_cmd_e        cmd;
   logic             step_fire;
   logic [WIDTH-1:0] rem_q;
   logic [WIDTH-1:0] div_q;
   ndiv_flags_t      flg_q;
   logic [WIDTH-1:0] rem_nx;
   ndiv_flags_t      flg_nx;

   ndiv_cmd_decode u_dec (
      .busy_i  (busy),
      .setup_i (setup_en),
      .run_i   (run_start),
      .step_i  (step_en),
      .cmd_o   (cmd)
   );

   ndiv_seq #(.RUN_STEPS(RUN_STEPS)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (cmd == CMD_RUN),
      .busy_o  (busy),
      .done_o  (done)
   );

   ndiv_step #(.WIDTH(WIDTH), .CB_STYLE(CB_STYLE)) u_step (
      .rem_i (rem_q),
      .div_i (div_q),
      .flg_i (flg_q),
      .rem_o (rem_nx),
      .flg_o (flg_nx)
   );

   assign step_fire = busy || (cmd == CMD_STEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         div_q <= '0;
         flg_q <= '0;
      end else if (cmd == CMD_SETUP) begin
         rem_q   <= setup_rem;
         div_q   <= setup_div;
         flg_q.q <= setup_q;
         flg_q.m <= setup_m;
         flg_q.t <= setup_t;
      end else if (step_fire) begin
         rem_q <= rem_nx;
         flg_q <= flg_nx;
      end
   end

   assign rem_out = rem_q;
   assign q_out   = flg_q.q;
   assign m_out   = flg_q.m;
   assign t_out   = flg_q.t;

endmodule

// File: rtl/ndiv_unit_chk.sv
module ndiv_unit_chk #(
   parameter int WIDTH     = 32,
   parameter int RUN_STEPS = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             setup_en,
   input logic             setup_q,
   input logic             setup_m,
   input logic             setup_t,
   input logic             step_en,
   input logic             run_start,
   input logic             step_fire,
   input logic [WIDTH-1:0] rem_out,
   input logic             q_out,
   input logic             m_out,
   input logic             t_out,
   input logic             busy,
   input logic             done
);

   localparam int RW = $clog2(RUN_STEPS + 2) + 1;

   // Counts busy cycles; long windows are checked here instead of by $past depth
   logic [RW-1:0] run_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_cnt <= '0;
      else if (busy)
         run_cnt <= run_cnt + 1'b1;
      else
         run_cnt <= '0;
   end

   p_setup_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (setup_en && !busy) |=> (q_out == $past(setup_q) && m_out == $past(setup_m)
                               && t_out == $past(setup_t)));

   p_t_rule_r5: assert property (@(posedge clk) disable iff (!rst_n)
      step_fire |=> (t_out == (q_out == m_out)));

   p_m_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      step_fire |=> $stable(m_out));

   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_fall_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   p_run_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (run_cnt == RW'(RUN_STEPS)));

   p_setup_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(m_out));

   p_no_extra_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_cnt < RW'(RUN_STEPS)));

   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !setup_en && !step_en && !run_start)
         |=> ($stable(rem_out) && $stable(q_out) && $stable(t_out)));

endmodule

bind ndiv_unit ndiv_unit_chk #(.WIDTH(WIDTH), .RUN_STEPS(RUN_STEPS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .setup_en  (setup_en),
   .setup_q   (setup_q),
   .setup_m   (setup_m),
   .setup_t   (setup_t),
   .step_en   (step_en),
   .run_start (run_start),
   .step_fire (step_fire),
   .rem_out   (rem_out),
   .q_out     (q_out),
   .m_out     (m_out),
   .t_out     (t_out),
   .busy      (busy),
   .done      (done)
);

// File: tb/sim_ndiv_unit.sv
module sim_ndiv_unit;

   localparam int W   = 32;
   localparam int RUN = 32;
   localparam int NV  = 8;

   // Each vector: {dividend, divisor, q, m, t}
   localparam logic [2*W+2:0] VEC [NV] = '{
      {32'h0000_0064, 32'h0000_0007, 3'b000},
      {32'h1234_5678, 32'h0000_1000, 3'b000},
      {32'hFFFF_FFFF, 32'h0000_0003, 3'b001},
      {32'h0000_0000, 32'hFFFF_FFF9, 3'b110},
      {32'h8000_0000, 32'h8000_0001, 3'b011},
      {32'h0000_0001, 32'h0000_0000, 3'b000},
      {32'hDEAD_BEEF, 32'hFFFF_0000, 3'b110},
      {32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b111}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         setup_en = 1'b0;
   logic [W-1:0] setup_rem = '0;
   logic [W-1:0] setup_div = '0;
   logic         setup_q = 1'b0, setup_m = 1'b0, setup_t = 1'b0;
   logic         step_en = 1'b0;
   logic         run_start = 1'b0;
   logic [W-1:0] rem_out;
   logic         q_out, m_out, t_out, busy, done;

   int total = 0;
   int fails = 0;
   int cyc = 0;
   bit finished = 0;

   // Reference state
   logic [W-1:0] mr, md;
   logic         mq, mm, mt;

   always #2 clk = ~clk;

   ndiv_unit #(.WIDTH(W), .RUN_STEPS(RUN)) u0 (
      .clk(clk), .rst_n(rst_n), .setup_en(setup_en), .setup_rem(setup_rem),
      .setup_div(setup_div), .setup_q(setup_q), .setup_m(setup_m),
      .setup_t(setup_t), .step_en(step_en), .run_start(run_start),
      .rem_out(rem_out), .q_out(q_out), .m_out(m_out), .t_out(t_out),
      .busy(busy), .done(done)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Reference step using a one-bit-wider adder (R3, R4, R5)
   task automatic model_step();
      logic [W:0] ext;
      logic [W-1:0] sh;
      logic top;
      top = mr[W-1];
      sh  = {mr[W-2:0], mt};
      if (mq == mm) ext = {1'b0, sh} - {1'b0, md};
      else          ext = {1'b0, sh} + {1'b0, md};
      mr = ext[W-1:0];
      mq = top ^ mm ^ ext[W];
      mt = (mq == mm);
   endtask

   task automatic do_setup(input logic [W-1:0] r, input logic [W-1:0] d,
                           input logic q, input logic m, input logic t);
      setup_en = 1'b1; setup_rem = r; setup_div = d;
      setup_q = q; setup_m = m; setup_t = t;
      @(negedge clk);
      setup_en = 1'b0;
      mr = r; md = d; mq = q; mm = m; mt = t;
   endtask

   task automatic check_state(input string req);
      chk(req, rem_out, mr);
      chk(req, {31'd0, q_out}, {31'd0, mq});
      chk(req, {31'd0, t_out}, {31'd0, mt});
      chk(req, {31'd0, m_out}, {31'd0, mm});
   endtask

   // disturb: 0 none, 1 setup, 2 step, 3 run_start, applied mid-run
   task automatic run_and_check(input int disturb, input string req);
      run_start = 1'b1;
      @(negedge clk);
      run_start = 1'b0;
      chk("R6 busy after start", {31'd0, busy}, 32'd1);
      for (int i = 0; i < RUN - 1; i++) begin
         if (i == 10) begin
            case (disturb)
               1: begin
                  setup_en = 1'b1; setup_rem = 32'hA5A5_A5A5; setup_div = 32'h1;
                  setup_q = ~mq; setup_m = ~mm; setup_t = ~mt;
               end
               2: step_en = 1'b1;
               3: run_start = 1'b1;
               default: ;
            endcase
         end
         @(negedge clk);
         setup_en = 1'b0; step_en = 1'b0; run_start = 1'b0;
      end
      chk("R6 busy before final", {31'd0, busy}, 32'd1);
      chk("R6 no early done", {31'd0, done}, 32'd0);
      @(negedge clk);
      for (int s = 0; s < RUN; s++) model_step();
      chk("R6 done at end", {31'd0, done}, 32'd1);
      chk("R6 busy fell", {31'd0, busy}, 32'd0);
      check_state(req);
      @(negedge clk);
      chk("R6 done one cycle", {31'd0, done}, 32'd0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !finished) begin
         fails++; total++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      mr = '0; md = '0; mq = 0; mm = 0; mt = 0;
      check_state("R1 reset");
      chk("R1 busy", {31'd0, busy}, 32'd0);
      chk("R1 done", {31'd0, done}, 32'd0);

      // Table-driven runs (R3 R4 R5 R6)
      for (int v = 0; v < NV; v++) begin
         do_setup(VEC[v][2*W+2:W+3], VEC[v][W+2:3], VEC[v][2], VEC[v][1], VEC[v][0]);
         check_state("R2 setup load");
         run_and_check(0, "R3 R4 R5 run result");
      end

      // Single steps with every Q/M combination (R3 R4 R5)
      for (int k = 0; k < 4; k++) begin
         do_setup(32'hC000_0001 ^ (k * 32'h1111_0000), 32'h9000_0003, k[1], k[0], k[0]);
         for (int s = 0; s < 3; s++) begin
            step_en = 1'b1;
            @(negedge clk);
            step_en = 1'b0;
            model_step();
            check_state("R4 single step");
            chk("R5 t rule", {31'd0, t_out}, {31'd0, q_out == m_out});
         end
      end

      // R10 idle hold
      repeat (3) @(negedge clk);
      check_state("R10 idle hold");

      // R7 setup ignored while busy
      do_setup(32'h0001_E240, 32'h0000_0123, 1'b0, 1'b0, 1'b0);
      run_and_check(1, "R7 setup ignored mid-run");

      // R8 step and run_start ignored while busy
      do_setup(32'hF0F0_1234, 32'hFFFF_FF00, 1'b1, 1'b1, 1'b0);
      run_and_check(2, "R8 step ignored mid-run");
      do_setup(32'h3333_CCCC, 32'h0000_0055, 1'b0, 1'b0, 1'b1);
      run_and_check(3, "R8 run_start ignored mid-run");

      // R9 setup beats run_start and step
      do_setup(32'h1111_1111, 32'h2, 1'b0, 1'b0, 1'b0);
      setup_en = 1'b1; run_start = 1'b1; step_en = 1'b1;
      setup_rem = 32'h0BAD_F00D; setup_div = 32'h0000_0011;
      setup_q = 1'b0; setup_m = 1'b0; setup_t = 1'b1;
      @(negedge clk);
      setup_en = 1'b0; run_start = 1'b0; step_en = 1'b0;
      mr = 32'h0BAD_F00D; md = 32'h11; mq = 0; mm = 0; mt = 1;
      chk("R9 setup wins no busy", {31'd0, busy}, 32'd0);
      check_state("R9 setup wins load");

      // R9 run_start beats step; accepting edge performs no step
      run_start = 1'b1; step_en = 1'b1;
      @(negedge clk);
      run_start = 1'b0; step_en = 1'b0;
      chk("R9 run wins busy", {31'd0, busy}, 32'd1);
      chk("R9 no step on start", rem_out, mr);
      repeat (RUN - 1) @(negedge clk);
      @(negedge clk);
      for (int s = 0; s < RUN; s++) model_step();
      chk("R9 run done", {31'd0, done}, 32'd1);
      check_state("R9 run result");

      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule